// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt sources into a register of pending flags and a separate register of enable bits. A rising edge on a source input latches its pending flag. Whenever some source is both pending and enabled, and the processor's master enable is on, the block raises a request to the processor. It also presents the fixed entry address of the source that ranks highest. The sources, from most to least urgent, are: the vertical blank, the display status condition (all display mode and line-compare causes share it), the timer overflow, the completion of a serial transfer, and a falling level on any keypad line.

When the processor takes the interrupt, it pulses the acknowledge input. Only the winning source's pending flag is cleared, and the master enable is dropped; any other requests stay pending. Software reads and writes both registers as bytes over a small register bus. It can also write pending flags directly. Clearing a flag before turning on its enable bit discards a stale request.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all pending flags, enable bits and the master enable are 0, `irq_o` is low, the flag register reads 0xE0 and the enable register reads 0x00.
- R2: A 0-to-1 transition on `src_i[k]` sets pending bit k at the next clock edge. A source held high does not set the flag again after the flag has been cleared.
- R3: `irq_o` is high exactly when the master enable is set and at least one bit of (pending AND enable) is 1. Masked sources do not raise it.
- R4: Bit 0 has the highest priority and bit 4 the lowest. `vec_o` equals 0x0040 + 8*k, where k is the lowest-numbered pending and enabled bit, giving 0x0040, 0x0048, 0x0050, 0x0058 or 0x0060.
- R5: An acknowledge clears only the pending flag of the winning source. All other pending flags keep their values.
- R6: The master enable is set by `mst_set_i` and cleared by `mst_clr_i` or by an acknowledge. An acknowledge takes precedence over `mst_set_i`, and `mst_clr_i` takes precedence over `mst_set_i`.
- R7: If a source edge and an acknowledge that clears the same flag occur at the same clock edge, the flag ends up set.
- R8: Bus address 0 selects the flag register and address 1 selects the enable register. A write replaces bits 4..0 and ignores bits 7..5. Bits 7..5 read as 1 in the flag register and as 0 in the enable register. Reads are combinational.
- R9: A software write of 0 to a pending flag withdraws its request before the enable is set, so no request follows. A software write of 1 raises a request exactly as a source edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 5 | Source request lines, bit 0 most urgent |
| bus_addr_i | input | 1 | Register select: 0 flags, 1 enables |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| mst_set_i | input | 1 | Turn master enable on |
| mst_clr_i | input | 1 | Turn master enable off |
| ack_i | input | 1 | Processor acknowledge |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 16 | Entry address of the winning source |
| mst_en_o | output | 1 | Master enable state |

## Verification
The hardest case to reach is an acknowledge that lands at the same clock edge as a fresh rising edge on the source being cleared. The bench arms source 0 through the bus, enables it, turns on the master enable, and then raises `src_i[0]` in the same cycle that `ack_i` is high. A second hard case is draining all five sources in order. Every flag is set with one software write, and the bench then acknowledges five times. Before each acknowledge it re-arms the master enable, so that the vector walk and the partial flag clears are visible after each step.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   typedef enum logic {
      REG_FLAGS  = 1'b0,
      REG_ENABLE = 1'b1
   } irq_reg_sel_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int unsigned NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] rise_o
);

   logic [NUM_SRC-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   assign rise_o = src_i & ~src_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned NUM_SRC   = 5,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned IDX_W    = irq_vec_pkg::idx_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic [NUM_SRC-1:0] grant_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               any_o
);

   generate
      if (LSB_FIRST) begin : g_lsb_first
         always_comb begin
            logic found;
            found   = 1'b0;
            grant_o = '0;
            idx_o   = '0;
            for (int i = 0; i < int'(NUM_SRC); i++) begin
               if (req_i[i] && !found) begin
                  found      = 1'b1;
                  grant_o[i] = 1'b1;
                  idx_o      = IDX_W'(i);
               end
            end
         end
      end else begin : g_msb_first
         always_comb begin
            logic found;
            found   = 1'b0;
            grant_o = '0;
            idx_o   = '0;
            for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
               if (req_i[i] && !found) begin
                  found      = 1'b1;
                  grant_o[i] = 1'b1;
                  idx_o      = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   assign any_o = |req_i;

   // R4: at most one source wins, and one wins whenever any is requesting
   p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (any_o == (grant_o != '0)));

   // R4: the winner is itself requesting
   p_grant_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter logic [15:0] VEC_BASE  = 16'h0040,
   parameter int unsigned VEC_STEP  = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         src_i,
   input  logic               bus_addr_i,
   input  logic               bus_we_i,
   input  logic [7:0]         bus_wdata_i,
   output logic [7:0]         bus_rdata_o,
   input  logic               mst_set_i,
   input  logic               mst_clr_i,
   input  logic               ack_i,
   output logic               irq_o,
   output logic [15:0]        vec_o,
   output logic               mst_en_o
);
   import irq_vec_pkg::*;

   localparam int unsigned IDX_W = idx_width(NUM_SRC);

   generate
      if (NUM_SRC != 5 || DATA_W != 8 || ADDR_W != 16) begin : g_bad_cfg
         $error("irq_vec_ctrl: port widths fix NUM_SRC=5, DATA_W=8, ADDR_W=16");
      end
      if (VEC_STEP == 0) begin : g_bad_step
         $error("irq_vec_ctrl: VEC_STEP must be nonzero");
      end
   endgenerate

   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] flag_q, flag_nxt;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] active;
   logic [NUM_SRC-1:0] grant;
   logic [IDX_W-1:0]   win_idx;
   logic               any_active;
   logic               mst_q;
   logic               wr_flags, wr_enable;

   irq_edge_det #(.NUM_SRC(NUM_SRC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .rise_o (rise)
   );

   assign active = flag_q & en_q;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .LSB_FIRST(LSB_FIRST)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (active),
      .grant_o (grant),
      .idx_o   (win_idx),
      .any_o   (any_active)
   );

   assign wr_flags  = bus_we_i && (irq_reg_sel_e'(bus_addr_i) == REG_FLAGS);
   assign wr_enable = bus_we_i && (irq_reg_sel_e'(bus_addr_i) == REG_ENABLE);

   // write, then acknowledge clear, then source set (set wins)
   always_comb begin
      flag_nxt = flag_q;
      if (wr_flags) flag_nxt = bus_wdata_i[NUM_SRC-1:0];
      if (ack_i)    flag_nxt = flag_nxt & ~grant;
      flag_nxt = flag_nxt | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
         mst_q  <= 1'b0;
      end else begin
         flag_q <= flag_nxt;
         if (wr_enable) en_q <= bus_wdata_i[NUM_SRC-1:0];
         if (ack_i || mst_clr_i) mst_q <= 1'b0;
         else if (mst_set_i)     mst_q <= 1'b1;
      end
   end

   always_comb begin
      if (irq_reg_sel_e'(bus_addr_i) == REG_FLAGS) begin
         bus_rdata_o = '1;
         bus_rdata_o[NUM_SRC-1:0] = flag_q;
      end else begin
         bus_rdata_o = '0;
         bus_rdata_o[NUM_SRC-1:0] = en_q;
      end
   end

   assign irq_o    = mst_q && any_active;
   assign mst_en_o = mst_q;
   assign vec_o    = VEC_BASE + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);

   // R2: an edge always lands in the flag register
   p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((flag_q & $past(rise)) == $past(rise)));

   // R5: acknowledge removes the winner unless a write or new edge refills it
   p_ack_clears_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !wr_flags && ((rise & grant) == '0)) |=> ((flag_q & $past(grant)) == '0));

   // R5: acknowledge leaves losing flags untouched
   p_ack_keeps_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !wr_flags) |=> ((flag_q & ~$past(grant)) == ($past(flag_q) & ~$past(grant)) | ($past(rise) & ~$past(grant))));

   // R6: acknowledge drops the master enable
   p_ack_drops_mst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !mst_en_o);

   // R3: no request without the master enable
   p_irq_needs_mst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> mst_en_o);

   // R4: vector stays inside the table while requesting
   p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o >= VEC_BASE && vec_o <= VEC_BASE + ADDR_W'((NUM_SRC - 1) * VEC_STEP)));

   // R8: unused flag bits read as ones
   always_comb begin
      if (rst_n && irq_reg_sel_e'(bus_addr_i) == REG_FLAGS) begin
         p_flag_upper_r8: assert (&bus_rdata_o[DATA_W-1:NUM_SRC]);
      end
   end

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_i = '0;
   logic        bus_addr_i = 1'b0;
   logic        bus_we_i = 1'b0;
   logic [7:0]  bus_wdata_i = '0;
   logic [7:0]  bus_rdata_o;
   logic        mst_set_i = 1'b0;
   logic        mst_clr_i = 1'b0;
   logic        ack_i = 1'b0;
   logic        irq_o;
   logic [15:0] vec_o;
   logic        mst_en_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   irq_vec_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .mst_set_i(mst_set_i), .mst_clr_i(mst_clr_i), .ack_i(ack_i),
      .irq_o(irq_o), .vec_o(vec_o), .mst_en_o(mst_en_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic bus_write(input logic addr, input logic [7:0] data);
      bus_addr_i  = addr;
      bus_wdata_i = data;
      bus_we_i    = 1'b1;
      tick();
      bus_we_i    = 1'b0;
   endtask

   task automatic bus_read(input logic addr, output logic [7:0] data);
      bus_addr_i = addr;
      #1;
      data = bus_rdata_o;
   endtask

   task automatic pulse_src(input int k);
      src_i[k] = 1'b1;
      tick();
      src_i[k] = 1'b0;
   endtask

   task automatic mst_on();
      mst_set_i = 1'b1;
      tick();
      mst_set_i = 1'b0;
   endtask

   task automatic do_ack();
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 irq", {15'd0, irq_o}, 16'd0);
      check("R1 mst", {15'd0, mst_en_o}, 16'd0);
      bus_read(1'b0, d); check("R1 flags", {8'd0, d}, 16'h00E0);
      bus_read(1'b1, d); check("R1 enable", {8'd0, d}, 16'h0000);
   endtask

   task automatic t_edge();
      logic [7:0] d;
      pulse_src(2);
      bus_read(1'b0, d); check("R2 edge sets bit2", {8'd0, d}, 16'h00E4);
      bus_write(1'b0, 8'h00);
      src_i[3] = 1'b1;
      tick();
      bus_read(1'b0, d); check("R2 level sets bit3", {8'd0, d}, 16'h00E8);
      bus_write(1'b0, 8'h00);
      tick(); tick();
      bus_read(1'b0, d); check("R2 held level no reset", {8'd0, d}, 16'h00E0);
      src_i[3] = 1'b0;
      tick();
   endtask

   task automatic t_bus();
      logic [7:0] d;
      bus_write(1'b1, 8'hFF);
      bus_read(1'b1, d); check("R8 enable upper zero", {8'd0, d}, 16'h001F);
      bus_write(1'b0, 8'hA5);
      bus_read(1'b0, d); check("R8 flag write low bits", {8'd0, d}, 16'h00E5);
      bus_write(1'b0, 8'h00);
      bus_write(1'b1, 8'h00);
   endtask

   task automatic t_stale_and_sw_set();
      pulse_src(1);
      bus_write(1'b0, 8'h00);
      bus_write(1'b1, 8'h02);
      mst_on();
      check("R9 stale cleared no irq", {15'd0, irq_o}, 16'd0);
      bus_write(1'b1, 8'h1F);
      bus_write(1'b0, 8'h10);
      check("R9 sw set raises irq", {15'd0, irq_o}, 16'd1);
      check("R4 vector bit4", vec_o, 16'h0060);
      mst_clr_i = 1'b1; tick(); mst_clr_i = 1'b0;
      check("R3 irq off with mst clear", {15'd0, irq_o}, 16'd0);
      bus_write(1'b0, 8'h00);
   endtask

   task automatic t_mask();
      bus_write(1'b1, 8'h04);
      bus_write(1'b0, 8'h1B);
      mst_on();
      check("R3 masked no irq", {15'd0, irq_o}, 16'd0);
      bus_write(1'b1, 8'h1A);
      check("R3 enabled irq", {15'd0, irq_o}, 16'd1);
      check("R4 vector bit1 under mask", vec_o, 16'h0048);
      bus_write(1'b0, 8'h00);
      mst_clr_i = 1'b1; tick(); mst_clr_i = 1'b0;
   endtask

   task automatic t_priority();
      logic [7:0] d;
      bus_write(1'b1, 8'h1F);
      bus_write(1'b0, 8'h1F);
      for (int k = 0; k < 5; k++) begin
         mst_on();
         check("R3 irq before ack", {15'd0, irq_o}, 16'd1);
         check("R4 vector walk", vec_o, 16'h0040 + 16'(8 * k));
         do_ack();
         check("R6 ack drops mst", {15'd0, mst_en_o}, 16'd0);
         bus_read(1'b0, d);
         check("R5 only winner cleared", {8'd0, d}, {8'd0, 8'hE0 | (8'h1F & ~((8'd2 << k) - 8'd1))});
      end
   endtask

   task automatic t_collision();
      logic [7:0] d;
      bus_write(1'b1, 8'h01);
      bus_write(1'b0, 8'h01);
      mst_on();
      ack_i = 1'b1;
      src_i[0] = 1'b1;
      tick();
      ack_i = 1'b0;
      src_i[0] = 1'b0;
      bus_read(1'b0, d); check("R7 set wins over ack", {8'd0, d}, 16'h00E1);
      check("R6 mst off after ack", {15'd0, mst_en_o}, 16'd0);
      bus_write(1'b0, 8'h00);
   endtask

   task automatic t_mst();
      mst_set_i = 1'b1; ack_i = 1'b1; tick();
      mst_set_i = 1'b0; ack_i = 1'b0;
      check("R6 ack beats set", {15'd0, mst_en_o}, 16'd0);
      mst_set_i = 1'b1; mst_clr_i = 1'b1; tick();
      mst_set_i = 1'b0; mst_clr_i = 1'b0;
      check("R6 clr beats set", {15'd0, mst_en_o}, 16'd0);
      mst_on();
      check("R6 set alone", {15'd0, mst_en_o}, 16'd1);
      mst_clr_i = 1'b1; tick(); mst_clr_i = 1'b0;
      check("R6 clr alone", {15'd0, mst_en_o}, 16'd0);
   endtask

   initial begin
      #20;
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_edge();
      t_bus();
      t_stale_and_sw_set();
      t_mask();
      t_priority();
      t_collision();
      t_mst();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule